// File: doc/BRIEF.md
# I2C Controller Register and Interrupt Unit

This block is the software-facing front of an I2C master. A processor reaches it through a word-addressed 32-bit register port. Writes to the command register queue bus commands into a command FIFO. Each command is a byte plus two flags, one asking for a START before the byte and one asking for a STOP after it. A separate bus engine drains the queue through a valid/ready handshake. The engine hands each byte it receives back through a one-cycle strobe, and those bytes collect in a receive FIFO that software empties by reading the RX data register.

The unit also holds the control word, the three bus timing counts and an interrupt block. The control word carries the enable bit, the speed select and two FIFO thresholds. The interrupt block has two level-driven ready conditions taken from the FIFO fill levels and three sticky error flags: NACK, arbitration loss and receive overflow. The error flags are cleared by writing one. A single level interrupt output is raised when any status bit is set together with its enable bit. Clearing the enable bit empties both FIFOs, so a disable followed by an enable returns the controller to a clean state.

Top module: `i2c_reg_unit`

## Requirements
- R1: After reset every readable register returns 0, both FIFO levels are 0, `irq` is 0 and `cmd_valid` is 0.
- R2: Word offsets are 0x00 command, 0x04 RX data, 0x08 control, 0x0C interrupt enable, 0x10 interrupt status, 0x14 core status, 0x18 command level, 0x1C RX level, 0x20 SCL low count, 0x24 SCL high count and 0x28 SDA hold count. The control register (6 bits), the enable register (5 bits) and the count registers (CNT_W bits) read back what was written, truncated to their width.
- R3: While enabled, a write to 0x00 queues bit 9 as START, bit 8 as STOP and bits 7:0 as the byte. The head entry is presented on `cmd_start`, `cmd_stop` and `cmd_byte` with `cmd_valid` high. One entry leaves on each cycle in which `cmd_valid` and `cmd_ready` are both high. Entries leave in the order they were written, and 0x18 reports the number of queued entries.
- R4: A command write while the command FIFO holds CMD_DEPTH entries (default 4) is dropped: the level stays at CMD_DEPTH and the queued entries are unchanged.
- R5: While enabled, each `rx_byte` strobed by `rx_valid` is appended to the RX FIFO, and 0x1C reports its level. Each read of 0x04 returns the oldest byte and removes it. A read of 0x04 when the FIFO is empty returns 0 and leaves the level at 0.
- R6: A received byte that arrives while the RX FIFO is full is discarded and sets status bit 4 (RX overflow).
- R7: Status bit 0 (TX ready) is 1 while enabled and the command level is at most T+1, where T is control bits 3:2.
- R8: Status bit 1 (RX ready) is 1 while enabled and the RX level is at least R+1, where R is control bits 5:4.
- R9: `nack_evt` sets status bit 2 and `arb_evt` sets status bit 3. Bits 2 to 4 stay set until a status write with a 1 in that position. Writing 0 to a bit leaves it unchanged.
- R10: `irq` is 1 exactly when some status bit and the same bit of the enable register (0x0C) are both 1.
- R11: Control bit 0 is the enable. While it is 0, both FIFOs are emptied, command writes and received bytes are ignored, `cmd_valid` is 0 and both ready bits are 0.
- R12: Bit 0 of the core status register is 1 while `engine_busy` is high or the command FIFO is not empty.
- R13: `core_en`, `fast_mode` (control bit 1) and the three count outputs follow the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| cmd_valid | output | 1 | Command FIFO head available to the engine |
| cmd_start | output | 1 | Head entry requests START |
| cmd_stop | output | 1 | Head entry requests STOP |
| cmd_byte | output | 8 | Head entry byte |
| cmd_ready | input | 1 | Engine accepts the head entry |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| nack_evt | input | 1 | NACK detected pulse |
| arb_evt | input | 1 | Arbitration lost pulse |
| engine_busy | input | 1 | Engine is mid-transfer |
| core_en | output | 1 | Enable bit to the engine |
| fast_mode | output | 1 | Speed select to the engine |
| scl_low_cnt | output | CNT_W | SCL low count |
| scl_high_cnt | output | CNT_W | SCL high count |
| sda_hold_cnt | output | CNT_W | SDA hold count |
| irq | output | 1 | Level interrupt |

## Verification
A faulty FIFO pointer or count is visible at the ports almost at once. The level registers drift away from the number of pushes minus pops. The command head shows a byte out of order on the next accepted pop, or an RX read returns a stale byte on the following read. A missed flush leaves a non-zero level readable one cycle after the enable is cleared. A sticky flag that is lost or cleared wrongly changes both the status word and `irq` on the cycle after the event or the write, so each flag is read back right after it is set, after a write of zero and after a write of one.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;

   localparam int WORD_W = 32;
   localparam int IRQ_N  = 5;
   localparam int CTRL_W = 6;
   localparam int THR_W  = 2;

   // word indices (byte offset >> 2)
   localparam logic [3:0] IDX_CMD   = 4'd0;
   localparam logic [3:0] IDX_RXD   = 4'd1;
   localparam logic [3:0] IDX_CTRL  = 4'd2;
   localparam logic [3:0] IDX_IEN   = 4'd3;
   localparam logic [3:0] IDX_ISTAT = 4'd4;
   localparam logic [3:0] IDX_CORE  = 4'd5;
   localparam logic [3:0] IDX_CLVL  = 4'd6;
   localparam logic [3:0] IDX_RLVL  = 4'd7;
   localparam logic [3:0] IDX_SCLLO = 4'd8;
   localparam logic [3:0] IDX_SCLHI = 4'd9;
   localparam logic [3:0] IDX_HOLD  = 4'd10;

   // interrupt bit positions
   localparam int IRQ_TXRDY = 0;
   localparam int IRQ_RXRDY = 1;
   localparam int IRQ_NACK  = 2;
   localparam int IRQ_ARB   = 3;
   localparam int IRQ_RXOF  = 4;

   typedef struct packed {
      logic       start;
      logic       stop;
      logic [7:0] payload;
   } cmd_word_t;

   localparam int CMD_W = $bits(cmd_word_t);

endpackage

// File: rtl/i2c_sync_fifo.sv
module i2c_sync_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("i2c_sync_fifo: DEPTH must be at least 1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("i2c_sync_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LVL_W-1:0] count;
   logic             do_push, do_pop;

   assign full    = (count == LVL_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;

   generate
      if ((DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0)) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   assign rdata = empty ? '0 : mem[rd_ptr];
   assign level = count;

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= LVL_W'(DEPTH)); // R4
   AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> full); // R4
   AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty); // R5

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
   import i2c_regs_pkg::*;
#(
   parameter int CMD_LVL_W = 3,
   parameter int RX_LVL_W  = 3,
   localparam int CMP_W = ((CMD_LVL_W > RX_LVL_W) ? CMD_LVL_W : RX_LVL_W) + THR_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 core_en,
   input  logic [CMD_LVL_W-1:0] cmd_level,
   input  logic [RX_LVL_W-1:0]  rx_level,
   input  logic [THR_W-1:0]     cmd_thr,
   input  logic [THR_W-1:0]     rx_thr,
   input  logic                 nack_evt,
   input  logic                 arb_evt,
   input  logic                 rxof_evt,
   input  logic [IRQ_N-1:0]     clr_mask,
   input  logic [IRQ_N-1:0]     en_mask,
   output logic [IRQ_N-1:0]     status,
   output logic                 irq
);

   localparam int STICKY_N = IRQ_N - 2;

   logic [CMP_W-1:0]    cmd_lvl_x, rx_lvl_x, cmd_lim, rx_lim;
   logic                tx_ready, rx_ready;
   logic [STICKY_N-1:0] sticky_q, sticky_evt, sticky_clr;

   assign cmd_lvl_x = CMP_W'(cmd_level);
   assign rx_lvl_x  = CMP_W'(rx_level);
   assign cmd_lim   = CMP_W'(cmd_thr) + 1'b1;
   assign rx_lim    = CMP_W'(rx_thr) + 1'b1;

   assign tx_ready = core_en && (cmd_lvl_x <= cmd_lim);
   assign rx_ready = core_en && (rx_lvl_x >= rx_lim);

   assign sticky_evt = {rxof_evt, arb_evt, nack_evt};
   assign sticky_clr = clr_mask[IRQ_N-1:2];

   generate
      for (genvar k = 0; k < STICKY_N; k++) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             sticky_q[k] <= 1'b0;
            else if (sticky_evt[k]) sticky_q[k] <= 1'b1;
            else if (sticky_clr[k]) sticky_q[k] <= 1'b0;
         end

         AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_q[k] && !sticky_clr[k]) |=> sticky_q[k]); // R9
         AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_clr[k] && !sticky_evt[k]) |=> !sticky_q[k]); // R9
      end
   endgenerate

   assign status = {sticky_q, rx_ready, tx_ready};
   assign irq    = |(status & en_mask);

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en_mask != '0)); // R10
   AST_READY_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en |-> (status[1:0] == 2'b00)); // R11

endmodule

// File: rtl/i2c_reg_unit.sv
module i2c_reg_unit
   import i2c_regs_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int CMD_DEPTH = 4,
   parameter int RX_DEPTH  = 4,
   parameter int CNT_W     = 16,
   localparam int CMD_LVL_W = $clog2(CMD_DEPTH + 1),
   localparam int RX_LVL_W  = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              cmd_valid,
   output logic              cmd_start,
   output logic              cmd_stop,
   output logic [7:0]        cmd_byte,
   input  logic              cmd_ready,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              nack_evt,
   input  logic              arb_evt,
   input  logic              engine_busy,
   output logic              core_en,
   output logic              fast_mode,
   output logic [CNT_W-1:0]  scl_low_cnt,
   output logic [CNT_W-1:0]  scl_high_cnt,
   output logic [CNT_W-1:0]  sda_hold_cnt
   ,output logic             irq
);

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("i2c_reg_unit: ADDR_W must cover offsets up to 0x28");
      end
      if (CNT_W < 1 || CNT_W > WORD_W) begin : g_bad_cnt
         $error("i2c_reg_unit: CNT_W must be within 1..32");
      end
      if (CMD_DEPTH < 1 || RX_DEPTH < 1) begin : g_bad_depth
         $error("i2c_reg_unit: FIFO depths must be at least 1");
      end
   endgenerate

   // ---------------- address decode ----------------
   logic [3:0] word_sel;
   logic       in_range;
   logic       wr_cmd, wr_ctrl, wr_ien, wr_istat, wr_lo, wr_hi, wr_hold;
   logic       rd_rxd;

   assign word_sel = reg_addr[5:2];
   generate
      if (ADDR_W > 6) begin : g_upper
         assign in_range = (reg_addr[ADDR_W-1:6] == '0) && (reg_addr[1:0] == 2'b00);
      end else begin : g_exact
         assign in_range = (reg_addr[1:0] == 2'b00);
      end
   endgenerate

   assign wr_cmd   = reg_wr && in_range && (word_sel == IDX_CMD);
   assign wr_ctrl  = reg_wr && in_range && (word_sel == IDX_CTRL);
   assign wr_ien   = reg_wr && in_range && (word_sel == IDX_IEN);
   assign wr_istat = reg_wr && in_range && (word_sel == IDX_ISTAT);
   assign wr_lo    = reg_wr && in_range && (word_sel == IDX_SCLLO);
   assign wr_hi    = reg_wr && in_range && (word_sel == IDX_SCLHI);
   assign wr_hold  = reg_wr && in_range && (word_sel == IDX_HOLD);
   assign rd_rxd   = reg_rd && in_range && (word_sel == IDX_RXD);

   // ---------------- stored registers ----------------
   logic [CTRL_W-1:0] ctrl_q;
   logic [IRQ_N-1:0]  ien_q;
   logic [CNT_W-1:0]  lo_q, hi_q, hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ien_q  <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         hold_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
         if (wr_ien)  ien_q  <= reg_wdata[IRQ_N-1:0];
         if (wr_lo)   lo_q   <= reg_wdata[CNT_W-1:0];
         if (wr_hi)   hi_q   <= reg_wdata[CNT_W-1:0];
         if (wr_hold) hold_q <= reg_wdata[CNT_W-1:0];
      end
   end

   logic [THR_W-1:0] cmd_thr, rx_thr;
   assign core_en      = ctrl_q[0];
   assign fast_mode    = ctrl_q[1];
   assign cmd_thr      = ctrl_q[3:2];
   assign rx_thr       = ctrl_q[5:4];
   assign scl_low_cnt  = lo_q;
   assign scl_high_cnt = hi_q;
   assign sda_hold_cnt = hold_q;

   // ---------------- command FIFO ----------------
   cmd_word_t             cmd_in, cmd_head;
   logic [CMD_LVL_W-1:0]  cmd_level;
   logic                  cmd_full, cmd_empty, cmd_pop, flush;

   assign flush  = !core_en;
   assign cmd_in = '{start: reg_wdata[9], stop: reg_wdata[8], payload: reg_wdata[7:0]};

   i2c_sync_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (wr_cmd),
      .wdata (cmd_in),
      .pop   (cmd_pop),
      .rdata (cmd_head),
      .level (cmd_level),
      .full  (cmd_full),
      .empty (cmd_empty)
   );

   assign cmd_valid = core_en && !cmd_empty;
   assign cmd_pop   = cmd_valid && cmd_ready;
   assign cmd_start = cmd_head.start;
   assign cmd_stop  = cmd_head.stop;
   assign cmd_byte  = cmd_head.payload;

   // ---------------- receive FIFO ----------------
   logic [7:0]           rx_head;
   logic [RX_LVL_W-1:0]  rx_level;
   logic                 rx_full, rx_empty, rx_push, rxof_evt;

   assign rx_push  = rx_valid && core_en;
   assign rxof_evt = rx_push && rx_full;

   i2c_sync_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (rx_push),
      .wdata (rx_byte),
      .pop   (rd_rxd),
      .rdata (rx_head),
      .level (rx_level),
      .full  (rx_full),
      .empty (rx_empty)
   );

   // ---------------- interrupts ----------------
   logic [IRQ_N-1:0] status, clr_mask;
   assign clr_mask = wr_istat ? reg_wdata[IRQ_N-1:0] : '0;

   i2c_irq_unit #(.CMD_LVL_W(CMD_LVL_W), .RX_LVL_W(RX_LVL_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_en   (core_en),
      .cmd_level (cmd_level),
      .rx_level  (rx_level),
      .cmd_thr   (cmd_thr),
      .rx_thr    (rx_thr),
      .nack_evt  (nack_evt),
      .arb_evt   (arb_evt),
      .rxof_evt  (rxof_evt),
      .clr_mask  (clr_mask),
      .en_mask   (ien_q),
      .status    (status),
      .irq       (irq)
   );

   // ---------------- read path ----------------
   logic [31:0] rd_mux;
   logic        core_busy;
   assign core_busy = engine_busy || !cmd_empty;

   always_comb begin
      rd_mux = '0;
      if (in_range) begin
         case (word_sel)
            IDX_RXD:   rd_mux = 32'(rx_head);
            IDX_CTRL:  rd_mux = 32'(ctrl_q);
            IDX_IEN:   rd_mux = 32'(ien_q);
            IDX_ISTAT: rd_mux = 32'(status);
            IDX_CORE:  rd_mux = 32'(core_busy);
            IDX_CLVL:  rd_mux = 32'(cmd_level);
            IDX_RLVL:  rd_mux = 32'(rx_level);
            IDX_SCLLO: rd_mux = 32'(lo_q);
            IDX_SCLHI: rd_mux = 32'(hi_q);
            IDX_HOLD:  rd_mux = 32'(hold_q);
            default:   rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   AST_FLUSH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en |=> (cmd_level == '0)); // R11
   AST_FLUSH_RX: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en |=> (rx_level == '0)); // R11
   AST_RXOF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && core_en && rx_full) |=> status[IRQ_RXOF]); // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && core_en && rx_full && !rd_rxd) |=> rx_full); // R6
   AST_CMD_ORDER_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pop && !wr_cmd) |=> (cmd_level == $past(cmd_level) - 1'b1)); // R3

endmodule

// File: tb/i2c_reg_unit_test.sv
module i2c_reg_unit_test;

   localparam int CNT_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cmd_valid, cmd_start, cmd_stop, cmd_ready = 1'b0;
   logic [7:0]  cmd_byte;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        nack_evt = 1'b0, arb_evt = 1'b0, engine_busy = 1'b0;
   logic        core_en, fast_mode, irq;
   logic [CNT_W-1:0] scl_low_cnt, scl_high_cnt, sda_hold_cnt;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk; // 50 MHz

   i2c_reg_unit #(.CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
      .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_byte(cmd_byte),
      .cmd_ready(cmd_ready), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .nack_evt(nack_evt), .arb_evt(arb_evt), .engine_busy(engine_busy),
      .core_en(core_en), .fast_mode(fast_mode), .scl_low_cnt(scl_low_cnt),
      .scl_high_cnt(scl_high_cnt), .sda_hold_cnt(sda_hold_cnt), .irq(irq)
   );

   localparam logic [5:0] A_CMD = 6'h00, A_RXD = 6'h04, A_CTRL = 6'h08, A_IEN = 6'h0C,
                          A_ISTAT = 6'h10, A_CORE = 6'h14, A_CLVL = 6'h18, A_RLVL = 6'h1C,
                          A_LO = 6'h20, A_HI = 6'h24, A_HOLD = 6'h28;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic rx_in(input logic [7:0] b);
      @(negedge clk);
      rx_byte = b; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic pop_cmd();
      @(negedge clk);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
   endtask

   task automatic pulse_evt(input bit is_arb);
      @(negedge clk);
      if (is_arb) arb_evt = 1'b1; else nack_evt = 1'b1;
      @(negedge clk);
      arb_evt = 1'b0; nack_evt = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 irq", 32'(irq), 0);
      check("R1 cmd_valid", 32'(cmd_valid), 0);
      rd_check("R1 ctrl", A_CTRL, 0);
      rd_check("R1 ien", A_IEN, 0);
      rd_check("R1 istat", A_ISTAT, 0);
      rd_check("R1 clvl", A_CLVL, 0);
      rd_check("R1 rlvl", A_RLVL, 0);
      rd_check("R1 lo", A_LO, 0);
   endtask

   task automatic t_regs();
      wr(A_LO, 32'hABCD_1234);
      wr(A_HI, 32'h0000_0456);
      wr(A_HOLD, 32'h0001_0789);
      rd_check("R2 scl low", A_LO, 32'h1234);
      rd_check("R2 scl high", A_HI, 32'h0456);
      rd_check("R2 hold", A_HOLD, 32'h0789);
      check("R13 low port", 32'(scl_low_cnt), 32'h1234);
      check("R13 high port", 32'(scl_high_cnt), 32'h0456);
      check("R13 hold port", 32'(sda_hold_cnt), 32'h0789);
      wr(A_CTRL, 32'hFFFF_FFB6);
      rd_check("R2 ctrl", A_CTRL, 32'h36);
      check("R13 fast", 32'(fast_mode), 1);
      check("R13 en", 32'(core_en), 0);
      wr(A_IEN, 32'hFFFF_FFE0);
      rd_check("R2 ien", A_IEN, 0);
      wr(A_CTRL, 0);
   endtask

   task automatic t_cmd();
      wr(A_CTRL, 32'h1);
      check("R13 en on", 32'(core_en), 1);
      wr(A_CMD, 32'h2A5);
      wr(A_CMD, 32'h001);
      wr(A_CMD, 32'h13C);
      rd_check("R3 level 3", A_CLVL, 3);
      rd_check("R12 busy from fifo", A_CORE, 1);
      check("R3 valid", 32'(cmd_valid), 1);
      check("R3 head", {cmd_start, cmd_stop, cmd_byte}, 32'h2A5);
      pop_cmd();
      check("R3 second", {cmd_start, cmd_stop, cmd_byte}, 32'h001);
      wr(A_CMD, 32'h0AA);
      wr(A_CMD, 32'h0BB);
      wr(A_CMD, 32'h0CC);       // dropped: fifo holds 4
      rd_check("R4 level stays 4", A_CLVL, 4);
      pop_cmd();
      check("R3 third", {cmd_start, cmd_stop, cmd_byte}, 32'h13C);
      pop_cmd();
      check("R4 fourth", {cmd_start, cmd_stop, cmd_byte}, 32'h0AA);
      pop_cmd();
      check("R4 last kept", {cmd_start, cmd_stop, cmd_byte}, 32'h0BB);
      pop_cmd();
      check("R4 drop not queued", 32'(cmd_valid), 0);
      rd_check("R3 drained", A_CLVL, 0);
      rd_check("R12 idle", A_CORE, 0);
      engine_busy = 1'b1;
      rd_check("R12 engine busy", A_CORE, 1);
      engine_busy = 1'b0;
   endtask

   task automatic t_txready();
      logic [31:0] v;
      rd(A_ISTAT, v); check("R7 empty ready", v & 1, 1);
      wr(A_CMD, 32'h10); wr(A_CMD, 32'h11);
      rd(A_ISTAT, v); check("R7 level2 thr0", v & 1, 0);
      wr(A_CTRL, 32'h5);
      rd(A_ISTAT, v); check("R7 level2 thr1", v & 1, 1);
      wr(A_CMD, 32'h12);
      rd(A_ISTAT, v); check("R7 level3 thr1", v & 1, 0);
      wr(A_CTRL, 32'h0);
      rd_check("R11 cmd flushed", A_CLVL, 0);
      rd(A_ISTAT, v); check("R11 ready off", v & 3, 0);
      wr(A_CMD, 32'h55);
      rd_check("R11 write ignored", A_CLVL, 0);
      check("R11 no valid", 32'(cmd_valid), 0);
   endtask

   task automatic t_rx();
      logic [31:0] v;
      wr(A_CTRL, 32'h21);
      rx_in(8'h11); rx_in(8'h22);
      rd_check("R5 level 2", A_RLVL, 2);
      rd(A_ISTAT, v); check("R8 below thr2", v & 2, 0);
      rx_in(8'h33);
      rd(A_ISTAT, v); check("R8 at thr2", v & 2, 2);
      rd_check("R5 first", A_RXD, 32'h11);
      rd_check("R5 second", A_RXD, 32'h22);
      rd_check("R5 third", A_RXD, 32'h33);
      rd_check("R5 empty read", A_RXD, 0);
      rd_check("R5 level 0", A_RLVL, 0);
      wr(A_CTRL, 32'h01);
      rx_in(8'h44);
      rd(A_ISTAT, v); check("R8 one elem", v & 2, 2);
      rx_in(8'h55); rx_in(8'h66); rx_in(8'h77);
      rd(A_ISTAT, v); check("R6 no ovf yet", v & 32'h10, 0);
      rx_in(8'h99);
      rd(A_ISTAT, v); check("R6 ovf set", v & 32'h10, 32'h10);
      rd_check("R6 level full", A_RLVL, 4);
      rd_check("R6 d0", A_RXD, 32'h44);
      rd_check("R6 d1", A_RXD, 32'h55);
      rd_check("R6 d2", A_RXD, 32'h66);
      rd_check("R6 d3 not dropped byte", A_RXD, 32'h77);
      wr(A_ISTAT, 32'h10);
      rd(A_ISTAT, v); check("R9 ovf cleared", v & 32'h10, 0);
      rx_in(8'h01); rx_in(8'h02);
      wr(A_CTRL, 32'h0);
      rd_check("R11 rx flushed", A_RLVL, 0);
      rx_in(8'h03);
      rd_check("R11 rx ignored", A_RLVL, 0);
   endtask

   task automatic t_sticky();
      logic [31:0] v;
      pulse_evt(1'b0);
      rd(A_ISTAT, v); check("R9 nack set", v & 32'h1C, 32'h04);
      wr(A_ISTAT, 32'h0);
      rd(A_ISTAT, v); check("R9 zero write keeps", v & 32'h1C, 32'h04);
      wr(A_ISTAT, 32'h4);
      rd(A_ISTAT, v); check("R9 nack cleared", v & 32'h1C, 0);
      pulse_evt(1'b1);
      check("R10 masked", 32'(irq), 0);
      wr(A_ISTAT, 32'h3);
      rd(A_ISTAT, v); check("R9 arb kept", v & 32'h1C, 32'h08);
      wr(A_IEN, 32'h08);
      check("R10 irq on", 32'(irq), 1);
      wr(A_ISTAT, 32'h08);
      check("R10 irq off", 32'(irq), 0);
      wr(A_IEN, 32'h01);
      check("R10 tx ready disabled", 32'(irq), 0);
      wr(A_CTRL, 32'h1);
      check("R10 tx ready irq", 32'(irq), 1);
      wr(A_IEN, 32'h0);
      check("R10 all masked", 32'(irq), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_cmd();
      t_txready();
      t_rx();
      t_sticky();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule